// File: doc/BRIEF.md
# Two-Wire Start Detector with Clock Stretching

This block watches the data and clock lines of a two-wire serial bus and reports a start condition: the data line going low while the clock line is high. The data line passes through a short chain of registers before it is compared with the clock. As a result, a data change that the master makes just after pulling the clock low is judged against a clock that is already low. A detected start sets a sticky flag. The flag drives an interrupt request, gated by an enable, and a wake request that is not gated. The wake request lets a system in deep sleep be brought back up.

Once a start has been seen, the block pulls the clock line low from the next clock-low phase onward. It keeps it low until software issues a release strobe. This gives the slave time to react. A shift-complete pulse from the data shifter also holds the clock low until the same release strobe arrives. Everything is active only while two-wire mode is selected.

Top module: `twi_start_watch`

## Requirements
- R1: With `tw_mode`=1, a 1-to-0 transition of the delayed data line while `scl_in`=1 sets `start_flag`.
- R2: `start_flag` rises exactly `SDA_DLY`+1 rising clock edges after `sda_in` is driven low, provided the clock line stays high.
- R3: A rising data line while the clock line is high (a stop) does not set `start_flag`. Data changes made while the clock line is low do not set it either, including bit traffic at one quarter of the system clock.
- R4: With `tw_mode`=0, `start_flag` never sets and `shift_done` has no effect on `scl_hold`.
- R5: `start_flag` is sticky and clears only on a `rel_strobe` pulse. If a start is detected in the same cycle as `rel_strobe`, the flag stays set.
- R6: `irq` is 1 exactly when `start_flag`=1 and `irq_en`=1.
- R7: `wake_req` is 1 whenever `start_flag`=1, whatever the value of `irq_en`.
- R8: After a start, `scl_hold` stays 0 while the clock line remains high. It rises one edge after the first cycle in which `scl_in`=0 is sampled with the flag set.
- R9: With `tw_mode`=1, a `shift_done` pulse makes `scl_hold`=1 from the next edge until a `rel_strobe`.
- R10: A `rel_strobe` pulse, with no `shift_done` in the same cycle, drops `start_flag` and `scl_hold` together at the next edge. The clock line is then no longer pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tw_mode | input | 1 | Two-wire mode select |
| sda_in | input | 1 | Synchronised data line |
| scl_in | input | 1 | Synchronised clock line |
| shift_done | input | 1 | Data shift complete pulse |
| rel_strobe | input | 1 | Software clear/release pulse |
| irq_en | input | 1 | Interrupt enable |
| start_flag | output | 1 | Sticky start-seen flag |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-from-sleep request |
| scl_hold | output | 1 | Pull clock line low (open-drain enable) |

## Verification
The two functions that can land in the same cycle are a new start detection and the software release strobe. The bench provokes this by pulsing `rel_strobe` in exactly the cycle in which the delayed data edge is being compared. It judges the result by requiring the flag to remain set afterwards, with the clock hold cleared until the next low phase. A second collision is `shift_done` arriving while a start hold is already active. That case is judged by checking that the hold persists and falls only at the release edge.

// File: rtl/twi_start_watch.sv
module twi_start_watch #(
  parameter int SDA_DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tw_mode,
  input  logic sda_in,
  input  logic scl_in,
  input  logic shift_done,
  input  logic rel_strobe,
  input  logic irq_en,
  output logic start_flag,
  output logic irq,
  output logic wake_req,
  output logic scl_hold
);

  logic [SDA_DLY-1:0] sda_pipe;
  logic sda_dly, sda_prev, det, low_seen, shift_pend;

  assign sda_dly = sda_pipe[SDA_DLY-1];
  assign det     = tw_mode && scl_in && sda_prev && !sda_dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_pipe   <= '1;
      sda_prev   <= 1'b1;
      start_flag <= 1'b0;
      low_seen   <= 1'b0;
      shift_pend <= 1'b0;
    end else begin
      sda_pipe[0] <= sda_in;
      for (int i = 1; i < SDA_DLY; i++) sda_pipe[i] <= sda_pipe[i-1];
      sda_prev <= sda_dly;

      if (det)             start_flag <= 1'b1;
      else if (rel_strobe) start_flag <= 1'b0;

      if (rel_strobe)                   low_seen <= 1'b0;
      else if (start_flag && !scl_in)   low_seen <= 1'b1;

      if (tw_mode && shift_done) shift_pend <= 1'b1;
      else if (rel_strobe)       shift_pend <= 1'b0;
    end
  end

  assign irq      = start_flag && irq_en;
  assign wake_req = start_flag;
  assign scl_hold = low_seen || shift_pend;

endmodule

module twi_start_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic tw_mode,
  input logic scl_in,
  input logic shift_done,
  input logic rel_strobe,
  input logic start_flag,
  input logic scl_hold
);

  // R1, R4: a flag can only rise after a cycle in two-wire mode with SCL high
  a_r1_rise_needs_mode_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_flag) |-> $past(tw_mode && scl_in));

  // R5: sticky without release
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag && !rel_strobe) |=> start_flag);

  // R10: release without shift pulse frees the clock line
  a_r10_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_strobe && !shift_done) |=> !scl_hold);

  // R8: hold rises only after a low clock or a shift pulse
  a_r8_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> $past(!scl_in || shift_done));

  // R9: shift pulse in two-wire mode holds the clock
  a_r9_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_mode && shift_done) |=> scl_hold);

endmodule

bind twi_start_watch twi_start_watch_chk u_chk (.*);

// File: tb/sim_twi_start_watch.sv
`timescale 1ns/1ps
module sim_twi_start_watch;
  localparam int DLY = 1;

  logic clk = 0, rst_n = 0;
  logic tw_mode = 0, sda_in = 1, scl_in = 1, shift_done = 0, rel_strobe = 0, irq_en = 0;
  logic start_flag, irq, wake_req, scl_hold;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  twi_start_watch #(.SDA_DLY(DLY)) u0 (.*);

  // fields: mode, en, kind[1:0] (0 start, 1 stop, 2 data bits), exp_flag, exp_irq
  localparam logic [5:0] VEC [5] = '{
    6'b1_1_00_1_1,
    6'b1_0_00_1_0,
    6'b1_1_01_0_0,
    6'b0_1_00_0_0,
    6'b1_1_10_0_0
  };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_release();
    rel_strobe = 1; tick(); rel_strobe = 0; tick();
  endtask

  task automatic bus_start();
    scl_in = 1; sda_in = 1; tick(3);
    sda_in = 0; tick(DLY + 3);
    scl_in = 0; tick(2);
  endtask

  task automatic bus_stop();
    scl_in = 0; tick(2); sda_in = 0; tick(2);
    scl_in = 1; tick(DLY + 3);
    sda_in = 1; tick(DLY + 3);
  endtask

  task automatic bus_bits();
    logic [4:0] pat = 5'b10110;
    for (int b = 4; b >= 0; b--) begin
      scl_in = 0; sda_in = pat[b]; tick(2);
      scl_in = 1; tick(2);
    end
    scl_in = 0; tick(2);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk); #2; tick(3);
    chk("R5 reset flag", start_flag, 0);
    chk("R6 reset irq", irq, 0);
    chk("R10 reset hold", scl_hold, 0);
    rst_n = 1; tick(2);

    for (int v = 0; v < 5; v++) begin
      tw_mode = VEC[v][5]; irq_en = VEC[v][4];
      case (VEC[v][3:2])
        2'd0: bus_start();
        2'd1: bus_stop();
        default: bus_bits();
      endcase
      chk($sformatf("R1/R3/R4 vec%0d flag", v), start_flag, VEC[v][1]);
      chk($sformatf("R6 vec%0d irq", v), irq, VEC[v][0]);
      chk($sformatf("R7 vec%0d wake", v), wake_req, VEC[v][1]);
      tw_mode = 1; do_release();
      scl_in = 1; sda_in = 1; tick(DLY + 3);
    end

    // R2 latency and R8 hold timing
    tw_mode = 1; irq_en = 1; scl_in = 1; sda_in = 1; tick(3);
    sda_in = 0; tick(DLY);
    chk("R2 flag not yet", start_flag, 0);
    tick();
    chk("R2 flag on time", start_flag, 1);
    tick(3);
    chk("R8 no hold while SCL high", scl_hold, 0);
    scl_in = 0;
    chk("R8 hold before low sampled", scl_hold, 0);
    tick();
    chk("R8 hold after low phase", scl_hold, 1);
    scl_in = 1; tick(2);
    chk("R8 hold persists", scl_hold, 1);

    // R10 release timing
    rel_strobe = 1;
    chk("R10 hold until edge", scl_hold, 1);
    tick(); rel_strobe = 0;
    chk("R10 flag cleared", start_flag, 0);
    chk("R10 hold released", scl_hold, 0);

    // repeated start: SCL low, SDA up, SCL up, SDA down
    scl_in = 0; tick(2); sda_in = 1; tick(2);
    scl_in = 1; tick(DLY + 2); sda_in = 0; tick(DLY + 2);
    chk("R1 repeated start", start_flag, 1);
    scl_in = 0; tick(2);
    do_release();

    // R5 start and release in the same cycle: set wins
    scl_in = 1; sda_in = 1; tick(DLY + 3);
    sda_in = 0; tick(DLY);
    rel_strobe = 1; tick(); rel_strobe = 0;
    chk("R5 set beats release", start_flag, 1);
    chk("R5 hold cleared by release", scl_hold, 0);

    // R9 shift pulse while a start hold is active
    scl_in = 0; tick();
    shift_done = 1; tick(); shift_done = 0;
    chk("R9 hold with shift pending", scl_hold, 1);
    do_release();
    chk("R10 hold dropped after shift", scl_hold, 0);
    shift_done = 1; tick(); shift_done = 0;
    chk("R9 shift alone holds", scl_hold, 1);
    do_release();

    // R4 shift pulse ignored with mode off
    tw_mode = 0; shift_done = 1; tick(); shift_done = 0; tick();
    chk("R4 shift ignored mode off", scl_hold, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule